// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Unit

This block takes one 4x4 block of signed residual coefficients and the matching 4x4 block of 8-bit prediction pixels, and returns the 4x4 block of reconstructed pixels. In full mode it runs a separable integer inverse transform: a 1-D butterfly on every row, then the same butterfly on every column. Each result is rounded by adding 32 and shifting right by six places. The rounded value is added to the prediction pixel, and the sum is clamped to 0..255.

A mode bit, sampled with the input handshake, picks DC-only reconstruction instead. In that mode only coefficient 0 is used. Its rounded value is added to all sixteen prediction pixels, and the other fifteen coefficients have no effect.

Each block is one transaction on a valid/ready handshake at both sides. The result is held in a single output register, so a block accepted on one edge is visible on the next. Coefficient and pixel index i is row*4+col. Coefficient i occupies bits [16i+15:16i] of the coefficient bus, and pixel i occupies bits [8i+7:8i] of the pixel buses.

Top module: `idct4_recon`

## Requirements
- R1: While reset is asserted and after it is released, out_valid_o is 0 and in_ready_o is 1 until a block is accepted.
- R2: A block is accepted on a rising edge with in_valid_i and in_ready_o both high. Its result appears with out_valid_o high after that edge. While out_valid_o is high and out_ready_i is low, pix_o holds its value and in_ready_o is low.
- R3: The 1-D stage on inputs x0..x3 forms e=x0+x2, f=x0-x2, g=(x1>>>1)-x3 and h=x1+(x3>>>1). It outputs o0=e+h, o1=f+g, o2=f-g and o3=e-h, and both shifts are arithmetic.
- R4: In full mode the 1-D stage is first applied to each row (indices r*4+0..3), and then to each column of the row results.
- R5: Each transformed value r becomes the residual (r+32)>>>6, with the addition wrapping at 16 bits.
- R6: Each output pixel is the residual plus the zero-extended prediction pixel, using signed 16-bit saturating addition, and then clamped to 0..255.
- R7: With dc_mode_i=1, every pixel uses coefficient 0 as r. Coefficients 1..15 have no effect.
- R8: A block of all-zero coefficients reproduces the prediction exactly.
- R9: All arithmetic inside the transform wraps at 16 bits. Only the prediction add saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Block can be accepted |
| dc_mode_i | input | 1 | 1 = DC-only, 0 = full transform |
| coef_i | input | 256 | Sixteen signed 16-bit coefficients |
| pred_i | input | 128 | Sixteen 8-bit prediction pixels |
| out_valid_o | output | 1 | Reconstructed block valid |
| out_ready_i | input | 1 | Downstream accepts the block |
| pix_o | output | 128 | Sixteen reconstructed 8-bit pixels |

## Verification
The bench builds the block with its default parameters: 16-bit coefficients, 8-bit pixels and a six-place rounding shift. At these values coefficients near full scale overflow the transform and the rounding addition, which brings the wrapping rule within reach. Coefficient-0 values of about 16000 drive the pixels to both clamp limits. Backpressure from a pseudo-random out_ready_i exercises the hold rule. Random full-mode blocks with asymmetric coefficients show whether the rows are transformed before the columns.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int BLK_DIM    = 4;
  localparam int BLK_PIX    = BLK_DIM * BLK_DIM;
  localparam int COEF_W_DEF = 16;
  localparam int PIX_W_DEF  = 8;
  localparam int RND_SH_DEF = 6;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_DC   = 1'b1
  } recon_mode_e;
endpackage

// File: rtl/idct4_stage.sv
module idct4_stage #(
  parameter int W = 16
) (
  input  logic [4*W-1:0] x_i,
  output logic [4*W-1:0] o_o
);
  logic signed [W-1:0] x0, x1, x2, x3;
  logic signed [W-1:0] e, f, g, h;
  logic signed [W-1:0] o0, o1, o2, o3;

  assign x0 = x_i[0*W +: W];
  assign x1 = x_i[1*W +: W];
  assign x2 = x_i[2*W +: W];
  assign x3 = x_i[3*W +: W];

  assign e = x0 + x2;
  assign f = x0 - x2;
  assign g = (x1 >>> 1) - x3;
  assign h = x1 + (x3 >>> 1);

  assign o0 = e + h;
  assign o1 = f + g;
  assign o2 = f - g;
  assign o3 = e - h;

  assign o_o = {o3, o2, o1, o0};

  logic [W-1:0] s03, s12, even2, odd2;
  assign s03   = o0 + o3;
  assign s12   = o1 + o2;
  assign even2 = (x0 + x2) << 1;
  assign odd2  = (x0 - x2) << 1;

  always_comb begin
    // R3
    even_pair_chk: assert (s03 == even2);
    // R3
    odd_pair_chk: assert (s12 == odd2);
  end
endmodule

// File: rtl/idct4_2d.sv
module idct4_2d
  import idct4_pkg::*;
#(
  parameter int W = COEF_W_DEF
) (
  input  logic [BLK_PIX*W-1:0] coef_i,
  output logic [BLK_PIX*W-1:0] res_o
);
  logic [BLK_PIX*W-1:0] row_res;

  // rows first (R4)
  for (genvar r = 0; r < BLK_DIM; r++) begin : g_row
    idct4_stage #(.W(W)) u_row (
      .x_i(coef_i[r*BLK_DIM*W +: BLK_DIM*W]),
      .o_o(row_res[r*BLK_DIM*W +: BLK_DIM*W])
    );
  end

  for (genvar c = 0; c < BLK_DIM; c++) begin : g_col
    logic [BLK_DIM*W-1:0] col_in, col_out;
    for (genvar k = 0; k < BLK_DIM; k++) begin : g_pick
      assign col_in[k*W +: W] = row_res[(k*BLK_DIM+c)*W +: W];
      assign res_o[(k*BLK_DIM+c)*W +: W] = col_out[k*W +: W];
    end
    idct4_stage #(.W(W)) u_col (
      .x_i(col_in),
      .o_o(col_out)
    );
  end
endmodule

// File: rtl/idct4_lane.sv
module idct4_lane #(
  parameter int W      = 16,
  parameter int PIX_W  = 8,
  parameter int RND_SH = 6
) (
  input  logic signed [W-1:0] r_i,
  input  logic [PIX_W-1:0]    pred_i,
  output logic [PIX_W-1:0]    pix_o
);
  localparam logic [W-1:0] RND_ADD = W'(1) << (RND_SH - 1);
  localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] biased, resid;
  logic        [W:0]   sum;
  logic        [W-1:0] sat;

  assign biased = r_i + RND_ADD;          // wraps
  assign resid  = biased >>> RND_SH;
  assign sum    = {resid[W-1], resid} + {1'b0, {(W-PIX_W){1'b0}}, pred_i};

  always_comb begin
    if (sum[W] != sum[W-1]) sat = sum[W] ? SAT_MIN : SAT_MAX;
    else                    sat = sum[W-1:0];
    if (sat[W-1])                pix_o = '0;
    else if (|sat[W-2:PIX_W])    pix_o = '1;
    else                         pix_o = sat[PIX_W-1:0];
  end

  always_comb begin
    // R8
    zero_pass_chk: assert (!(r_i == '0) || (pix_o == pred_i));
  end
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
  import idct4_pkg::*;
#(
  parameter int COEF_W = COEF_W_DEF,
  parameter int PIX_W  = PIX_W_DEF,
  parameter int RND_SH = RND_SH_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic                      dc_mode_i,
  input  logic [BLK_PIX*COEF_W-1:0] coef_i,
  input  logic [BLK_PIX*PIX_W-1:0]  pred_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [BLK_PIX*PIX_W-1:0]  pix_o
);
  recon_mode_e                mode;
  logic [BLK_PIX*COEF_W-1:0]  xf_res;
  logic [BLK_PIX*PIX_W-1:0]   pix_d, pix_q;
  logic                       valid_q, accept;

  assign mode = recon_mode_e'(dc_mode_i);

  idct4_2d #(.W(COEF_W)) u_xf (
    .coef_i(coef_i),
    .res_o (xf_res)
  );

  for (genvar i = 0; i < BLK_PIX; i++) begin : g_lane
    logic signed [COEF_W-1:0] r_sel;
    // DC mode bypasses the transform with coefficient 0
    assign r_sel = (mode == MODE_DC) ? coef_i[0 +: COEF_W] : xf_res[i*COEF_W +: COEF_W];
    idct4_lane #(.W(COEF_W), .PIX_W(PIX_W), .RND_SH(RND_SH)) u_lane (
      .r_i   (r_sel),
      .pred_i(pred_i[i*PIX_W +: PIX_W]),
      .pix_o (pix_d[i*PIX_W +: PIX_W])
    );
  end

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      pix_q   <= pix_d;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign pix_o       = pix_q;

  // R2
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(pix_o));
  // R2
  accept_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);
  // R2
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
endmodule

// File: tb/idct4_recon_test.sv
`timescale 1ns/1ps
module idct4_recon_test;
  localparam int W = 16, PW = 8, N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid, in_ready, dc_mode, out_valid, out_ready;
  logic [N*W-1:0]  coef;
  logic [N*PW-1:0] pred, pix;

  idct4_recon uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .dc_mode_i(dc_mode), .coef_i(coef), .pred_i(pred),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .pix_o(pix)
  );

  int n_cmp = 0, n_bad = 0;
  logic [N*PW-1:0] exp_q[$];
  string           tag_q[$];
  bit              stall_en = 0;
  logic [15:0]     lfsr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign out_ready = !stall_en || lfsr[0] || lfsr[3];

  task automatic chk(bit ok, string tag, logic [N*PW-1:0] act, logic [N*PW-1:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int w16(int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic void stage(ref int a[4]);
    int e, f, g, h;
    e = w16(a[0] + a[2]);
    f = w16(a[0] - a[2]);
    g = w16((a[1] >>> 1) - a[3]);
    h = w16(a[1] + (a[3] >>> 1));
    a[0] = w16(e + h); a[1] = w16(f + g); a[2] = w16(f - g); a[3] = w16(e - h);
  endfunction

  function automatic logic [N*PW-1:0] ref_blk(logic [N*W-1:0] c, logic [N*PW-1:0] p, bit dc);
    int m[16];
    int v[4];
    logic [N*PW-1:0] r;
    for (int i = 0; i < 16; i++) m[i] = w16(int'(signed'(c[i*W +: W])));
    if (dc) begin
      for (int i = 1; i < 16; i++) m[i] = m[0];
    end else begin
      for (int row = 0; row < 4; row++) begin
        for (int k = 0; k < 4; k++) v[k] = m[row*4+k];
        stage(v);
        for (int k = 0; k < 4; k++) m[row*4+k] = v[k];
      end
      for (int col = 0; col < 4; col++) begin
        for (int k = 0; k < 4; k++) v[k] = m[k*4+col];
        stage(v);
        for (int k = 0; k < 4; k++) m[k*4+col] = v[k];
      end
    end
    for (int i = 0; i < 16; i++) begin
      int s;
      s = (w16(m[i] + 32) >>> 6) + int'(p[i*PW +: PW]);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      r[i*PW +: PW] = s[7:0];
    end
    return r;
  endfunction

  task automatic send(logic [N*W-1:0] c, logic [N*PW-1:0] p, bit dc, string tag);
    @(negedge clk);
    coef = c; pred = p; dc_mode = dc; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(ref_blk(c, p, dc));
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [N*W-1:0] rnd_coef(int span);
    logic [N*W-1:0] c;
    for (int i = 0; i < N; i++) c[i*W +: W] = 16'(int'($urandom_range(2*span, 0)) - span);
    return c;
  endfunction

  function automatic logic [N*PW-1:0] rnd_pred();
    logic [N*PW-1:0] p;
    for (int i = 0; i < N; i++) p[i*PW +: PW] = 8'($urandom);
    return p;
  endfunction

  function automatic logic [N*PW-1:0] flat_pred(int v);
    logic [N*PW-1:0] p;
    for (int i = 0; i < N; i++) p[i*PW +: PW] = 8'(v);
    return p;
  endfunction

  // output monitor, compared on every clock
  logic            prev_stall = 1'b0;
  logic [N*PW-1:0] prev_pix;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) chk(out_valid && pix == prev_pix, "R2 hold under stall", pix, prev_pix);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected output", pix, '0);
        else begin
          logic [N*PW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(pix == e, t, pix, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pix   = pix;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog expired, pending=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    logic [N*W-1:0] c;
    in_valid = 1'b0; dc_mode = 1'b0; coef = '0; pred = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1 during reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

    send('0, rnd_pred(), 1'b0, "R8 zero block");
    send('0, flat_pred(255), 1'b0, "R8 zero block flat");
    for (int k = 0; k < 10; k++) send(rnd_coef(2000), rnd_pred(), 1'b0, "R3 R4 random full");
    c = '0; c[1*W +: W] = 16'd700; c[6*W +: W] = -16'sd900;
    send(c, flat_pred(128), 1'b0, "R4 asymmetric block");
    c = '0; c[0 +: W] = 16'd16000;
    send(c, flat_pred(200), 1'b0, "R6 clamp high");
    c = '0; c[0 +: W] = -16'sd16000;
    send(c, flat_pred(50), 1'b0, "R6 clamp low");
    c = '0; c[0 +: W] = 16'd31;
    send(c, rnd_pred(), 1'b0, "R5 round down");
    c = '0; c[0 +: W] = 16'd32;
    send(c, rnd_pred(), 1'b0, "R5 round up");
    c = '0; c[0 +: W] = 16'd32767;
    send(c, flat_pred(100), 1'b0, "R5 R9 rounding wrap");
    for (int k = 0; k < 6; k++) send(rnd_coef(32767), rnd_pred(), 1'b0, "R9 full range wrap");
    c = rnd_coef(20000); c[0 +: W] = 16'd640;
    send(c, rnd_pred(), 1'b1, "R7 dc ignores others");
    c = rnd_coef(20000); c[0 +: W] = 16'd32000;
    send(c, rnd_pred(), 1'b1, "R7 dc clamp high");
    c = rnd_coef(20000); c[0 +: W] = -16'sd32000;
    send(c, rnd_pred(), 1'b1, "R7 dc clamp low");
    idle();

    stall_en = 1;
    for (int k = 0; k < 120; k++)
      send(rnd_coef(($urandom_range(1) == 1) ? 32767 : 3000), rnd_pred(),
           bit'($urandom_range(3) == 0), "R2 R3 R7 stalled mix");
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule